// File: doc/BRIEF.md
# Coherent Live Counter Sampler

This block reads a 16-bit down-counter that keeps running while it is read. The counter sits behind an 8-bit register port with a byte-select flip-flop. A clear access resets that flip-flop. Each read access then returns the low byte first and the high byte next. Because the counter is never paused, a single low/high pair can be torn by a borrow out of the low byte. The sampler therefore reads the counter twice and keeps the pair that the borrow could not have split. It then turns the chosen raw count into a remaining-transfer length.

A client pulses a start strobe with a channel number and a flag that marks the channel as one that moves 16-bit words. The sampler first checks the channel against three per-channel bitmaps: acquired, busy and auto-reload. If the channel fails the check, the sampler answers at once with an error code and makes no port access. Otherwise it runs six accesses on the request/acknowledge port, one after another. It then reports the result with a one-cycle done pulse and holds the result and status until its next completion.

Top module: `live_count_sampler`

## Requirements
- R1: A sample issues exactly six port accesses in this order: clear, read, read, clear, read, read. `port_op_o` is 0 for a clear and 1 for a read. `port_chan_o` carries the latched channel on every access.
- R2: Each access holds `port_req_o` high with a stable `port_op_o` until a cycle in which `port_ack_i` is high. The next access starts no earlier than the cycle after that acknowledge. Read data is taken from `port_rdata_i` in the acknowledge cycle.
- R3: Call the four read bytes low1, high1, low2 and high2, in access order. If low1 ≥ low2, the count is formed from high1 and low1. Otherwise it is formed from high2 and low2.
- R4: The reported count is (high×256 + low + 1) modulo 65536. A raw reading of 0xFFFF therefore reports 0.
- R5: When the word flag was set at start, the 17-bit result is the count shifted left by one. Otherwise the result is the count zero-extended to 17 bits.
- R6: A start on a channel whose acquired bit is 0 produces, one cycle later, a done pulse with `status_o` = 1 and result 0. It makes no port access. This check has priority over R7.
- R7: A start on an acquired channel whose busy and auto-reload bits are both 0 produces, one cycle later, a done pulse with `status_o` = 2 and result 0. It makes no port access.
- R8: A start strobe seen while a sample is in progress is ignored. The channel, word flag, access sequence and result of the running sample are unchanged.
- R9: `done_o` is high for exactly one cycle. It follows the clock edge that takes the sixth acknowledge. A successful sample gives `status_o` = 0. `result_o` and `status_o` hold their values until the next done pulse.
- R10: After reset, `port_req_o` and `done_o` are low, and `result_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| chan_i | input | 3 | Channel to sample |
| word_i | input | 1 | Channel moves 16-bit words |
| chan_active_i | input | 8 | Per-channel acquired bits |
| chan_busy_i | input | 8 | Per-channel busy bits |
| chan_auto_i | input | 8 | Per-channel auto-reload bits |
| port_req_o | output | 1 | Port access request |
| port_op_o | output | 1 | Access kind: 0 clear flip-flop, 1 read byte |
| port_chan_o | output | 3 | Channel addressed by the access |
| port_ack_i | input | 1 | Access acknowledge |
| port_rdata_i | input | 8 | Byte returned by a read |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 channel not acquired, 2 channel idle |
| result_o | output | 17 | Remaining bytes or words-as-bytes |

## Verification
The sequencer's state shows at the ports first in the access stream. A step counter that is off, or that moves without an acknowledge, gives a wrong `port_op_o` on the very next request, or a request that drops early. Captured bytes that are stored in the wrong slot, or a wrong pair choice, show only when done is reported. For that reason the stimulus decrements the served counter at chosen points, which makes torn and untorn pairs. A stale latched channel or word flag shows on `port_chan_o` at the next access, or in the scaling of the result.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_INACTIVE = 2'd1,
        ST_NOTBUSY  = 2'd2
    } stat_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_ACC  = 1'b1
    } fsm_e;

endpackage

// File: rtl/lcs_gate.sv
module lcs_gate
    import lcs_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [CH_W-1:0] chan_i,
    input  logic [NCH-1:0]  active_i,
    input  logic [NCH-1:0]  busy_i,
    input  logic [NCH-1:0]  auto_i,
    output stat_e           status_o
);

    // Not-acquired outranks not-busy.
    always_comb begin
        if (!active_i[chan_i]) begin
            status_o = ST_INACTIVE;
        end else if (!busy_i[chan_i] && !auto_i[chan_i]) begin
            status_o = ST_NOTBUSY;
        end else begin
            status_o = ST_OK;
        end
    end

endmodule

// File: rtl/lcs_pick.sv
module lcs_pick #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16,
    parameter int RES_W  = CNT_W + 1
) (
    input  logic [BYTE_W-1:0]       lo1_i,
    input  logic [CNT_W-BYTE_W-1:0] hi1_i,
    input  logic [BYTE_W-1:0]       lo2_i,
    input  logic [CNT_W-BYTE_W-1:0] hi2_i,
    input  logic                    word_i,
    output logic [RES_W-1:0]        res_o
);

    logic [CNT_W-1:0] raw;
    logic [CNT_W-1:0] inc;

    always_comb begin
        // A borrow between the two low reads makes low2 larger: pair 2 is whole.
        raw = (lo1_i >= lo2_i) ? {hi1_i, lo1_i} : {hi2_i, lo2_i};
        // Terminal count leaves all ones; the +1 wraps it to zero.
        inc = raw + CNT_W'(1);
        res_o = word_i ? {inc, 1'b0} : {1'b0, inc};
    end

endmodule

// File: rtl/lcs_seq.sv
module lcs_seq
    import lcs_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16,
    parameter int RES_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              word_i,
    input  stat_e             gate_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              req_o,
    output op_e               op_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              done_o,
    output stat_e             status_o,
    output logic [RES_W-1:0]  result_o
);

    localparam int HI_W   = CNT_W - BYTE_W;
    localparam int NSTEP  = 6;
    localparam int STEP_W = $clog2(NSTEP);
    localparam int HALF   = NSTEP / 2;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

    typedef struct packed {
        fsm_e              st;
        logic [STEP_W-1:0] step;
        logic [CH_W-1:0]   chan;
        logic              word;
        logic [BYTE_W-1:0] lo1;
        logic [HI_W-1:0]   hi1;
        logic [BYTE_W-1:0] lo2;
        logic              done;
        stat_e             status;
        logic [RES_W-1:0]  result;
    } regs_t;

    regs_t r_d, r_q;
    logic [RES_W-1:0] pick_res;

    // The second high byte is used straight from the port in its ack cycle.
    lcs_pick #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W),
        .RES_W  (RES_W)
    ) u_pick (
        .lo1_i  (r_q.lo1),
        .hi1_i  (r_q.hi1),
        .lo2_i  (r_q.lo2),
        .hi2_i  (rdata_i[HI_W-1:0]),
        .word_i (r_q.word),
        .res_o  (pick_res)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            FSM_IDLE: begin
                if (start_i) begin
                    if (gate_i != ST_OK) begin
                        r_d.done   = 1'b1;
                        r_d.status = gate_i;
                        r_d.result = '0;
                    end else begin
                        r_d.st   = FSM_ACC;
                        r_d.step = '0;
                        r_d.chan = chan_i;
                        r_d.word = word_i;
                    end
                end
            end
            FSM_ACC: begin
                if (ack_i) begin
                    if (r_q.step == STEP_W'(1)) r_d.lo1 = rdata_i;
                    if (r_q.step == STEP_W'(2)) r_d.hi1 = rdata_i[HI_W-1:0];
                    if (r_q.step == STEP_W'(4)) r_d.lo2 = rdata_i;
                    if (r_q.step == LAST) begin
                        r_d.st     = FSM_IDLE;
                        r_d.done   = 1'b1;
                        r_d.status = ST_OK;
                        r_d.result = pick_res;
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                    end
                end
            end
            default: r_d.st = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_o    = (r_q.st == FSM_ACC);
        op_o     = ((r_q.step == '0) || (r_q.step == STEP_W'(HALF))) ? OP_CLEAR : OP_READ;
        chan_o   = r_q.chan;
        done_o   = r_q.done;
        status_o = r_q.status;
        result_o = r_q.result;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(op_o)));

    assert_clear_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && op_o == OP_CLEAR) |=> (req_o && op_o == OP_READ));

    assert_chan_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !(ack_i && r_q.step == LAST)) |=> $stable(chan_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/live_count_sampler.sv
module live_count_sampler
    import lcs_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16,
    localparam int CH_W  = $clog2(NCH),
    localparam int RES_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              word_i,
    input  logic [NCH-1:0]    chan_active_i,
    input  logic [NCH-1:0]    chan_busy_i,
    input  logic [NCH-1:0]    chan_auto_i,
    output logic              port_req_o,
    output logic              port_op_o,
    output logic [CH_W-1:0]   port_chan_o,
    input  logic              port_ack_i,
    input  logic [BYTE_W-1:0] port_rdata_i,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [RES_W-1:0]  result_o
);

    stat_e gate_st;
    op_e   op_s;
    stat_e stat_s;

    lcs_gate #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_gate (
        .chan_i   (chan_i),
        .active_i (chan_active_i),
        .busy_i   (chan_busy_i),
        .auto_i   (chan_auto_i),
        .status_o (gate_st)
    );

    lcs_seq #(
        .CH_W   (CH_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W),
        .RES_W  (RES_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .chan_i   (chan_i),
        .word_i   (word_i),
        .gate_i   (gate_st),
        .ack_i    (port_ack_i),
        .rdata_i  (port_rdata_i),
        .req_o    (port_req_o),
        .op_o     (op_s),
        .chan_o   (port_chan_o),
        .done_o   (done_o),
        .status_o (stat_s),
        .result_o (result_o)
    );

    assign port_op_o = op_s;
    assign status_o  = stat_s;

    assert_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !port_req_o && !chan_active_i[chan_i])
        |=> (done_o && status_o == 2'd1 && !port_req_o && result_o == '0));

    assert_notbusy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !port_req_o && chan_active_i[chan_i]
         && !chan_busy_i[chan_i] && !chan_auto_i[chan_i])
        |=> (done_o && status_o == 2'd2 && !port_req_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_req_o && !start_i) |=> ($stable(result_o) && $stable(status_o)));

    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req_o && !port_ack_i) |=> ($stable(result_o) && !done_o));

endmodule

// File: tb/tb_live_count_sampler.sv
module tb_live_count_sampler;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic        word_i = 1'b0;
    logic [7:0]  chan_active_i = 8'b1011_1111;
    logic [7:0]  chan_busy_i   = 8'b0100_1111;
    logic [7:0]  chan_auto_i   = 8'b0011_0000;
    logic        port_req_o;
    logic        port_op_o;
    logic [2:0]  port_chan_o;
    logic        port_ack_i = 1'b0;
    logic [7:0]  port_rdata_i = '0;
    logic        done_o;
    logic [1:0]  status_o;
    logic [16:0] result_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    live_count_sampler dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .chan_i        (chan_i),
        .word_i        (word_i),
        .chan_active_i (chan_active_i),
        .chan_busy_i   (chan_busy_i),
        .chan_auto_i   (chan_auto_i),
        .port_req_o    (port_req_o),
        .port_op_o     (port_op_o),
        .port_chan_o   (port_chan_o),
        .port_ack_i    (port_ack_i),
        .port_rdata_i  (port_rdata_i),
        .done_o        (done_o),
        .status_o      (status_o),
        .result_o      (result_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_result(input logic [7:0] l1, input logic [7:0] h1,
                                               input logic [7:0] l2, input logic [7:0] h2,
                                               input bit wrd);
        logic [15:0] v;
        v = (l1 >= l2) ? {h1, l1} : {h2, l2};
        v = v + 16'd1;
        return wrd ? {v, 1'b0} : {1'b0, v};
    endfunction

    // One full sample; the bench acts as the byte port of a live counter.
    task automatic do_sample(input logic [2:0] ch, input bit wrd, input logic [15:0] cnt0,
                             input int dec_at, input int dec_amt, input bit intrude,
                             input int fixed_exp);
        logic [15:0] cnt;
        logic [7:0]  b [6];
        bit          ff;
        logic [16:0] exp;
        cnt = cnt0;
        ff  = 1'b0;
        start_i = 1'b1; chan_i = ch; word_i = wrd;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            int guard;
            int dly;
            guard = 0;
            if (k == dec_at) cnt = cnt - 16'(dec_amt);
            while (!port_req_o && guard < 20) begin
                @(negedge clk);
                guard++;
            end
            check(port_req_o == 1'b1, "R2 request present", int'(port_req_o), 1);
            check(port_op_o == ((k % 3 == 0) ? 1'b0 : 1'b1), "R1 access kind",
                  int'(port_op_o), (k % 3 == 0) ? 0 : 1);
            check(port_chan_o == ch, "R1/R8 access channel", int'(port_chan_o), int'(ch));
            dly = (intrude && k == 2) ? 2 : int'($urandom % 3);
            for (int d = 0; d < dly; d++) begin
                if (intrude && k == 2 && d == 0) begin
                    start_i = 1'b1; chan_i = ch ^ 3'd1; word_i = ~wrd;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
                check(port_req_o && port_op_o == ((k % 3 == 0) ? 1'b0 : 1'b1),
                      "R2 hold without ack", int'({port_req_o, port_op_o}), 1);
            end
            start_i = 1'b0; chan_i = ch; word_i = wrd;
            if (k % 3 == 0) begin
                ff   = 1'b0;
                b[k] = 8'($urandom);
            end else begin
                b[k] = ff ? cnt[15:8] : cnt[7:0];
                ff   = ~ff;
            end
            port_ack_i = 1'b1; port_rdata_i = b[k];
            @(negedge clk);
            port_ack_i = 1'b0; port_rdata_i = 8'($urandom);
        end
        exp = exp_result(b[1], b[2], b[4], b[5], wrd);
        if (fixed_exp >= 0) check(int'(exp) == fixed_exp, "R3/R4/R5 bench model", int'(exp), fixed_exp);
        check(done_o == 1'b1, "R9 done after last ack", int'(done_o), 1);
        check(status_o == 2'd0, "R9 status ok", int'(status_o), 0);
        check(result_o == exp, "R3/R4/R5 result", int'(result_o), int'(exp));
        check(port_req_o == 1'b0, "R1 six accesses only", int'(port_req_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
        check(result_o == exp, "R9 result held", int'(result_o), int'(exp));
    endtask

    task automatic do_error(input logic [2:0] ch, input logic [1:0] exp_st, input string tag);
        start_i = 1'b1; chan_i = ch; word_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, tag, int'(done_o), 1);
        check(status_o == exp_st, tag, int'(status_o), int'(exp_st));
        check(result_o == 17'd0, tag, int'(result_o), 0);
        check(port_req_o == 1'b0, tag, int'(port_req_o), 0);
        @(negedge clk);
        check(done_o == 1'b0 && port_req_o == 1'b0, tag, int'({done_o, port_req_o}), 0);
        check(status_o == exp_st, "R9 status held", int'(status_o), int'(exp_st));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(port_req_o == 1'b0 && done_o == 1'b0, "R10 reset outputs",
              int'({port_req_o, done_o}), 0);
        check(result_o == 17'd0 && status_o == 2'd0, "R10 reset result",
              int'(result_o), 0);

        do_sample(3'd0, 1'b0, 16'h1234, -1, 0, 1'b0, 17'h01235);  // R4 plain
        do_sample(3'd1, 1'b0, 16'hFFFF, -1, 0, 1'b0, 0);          // R4 terminal wrap
        do_sample(3'd4, 1'b1, 16'hFFFF, -1, 0, 1'b0, 0);          // R5 wrap on word channel
        do_sample(3'd2, 1'b0, 16'h1200, 2, 1, 1'b0, 17'h01200);   // R3 torn first pair
        do_sample(3'd3, 1'b0, 16'h3400, 5, 1, 1'b0, 17'h03401);   // R3 equal lows keep pair 1
        do_sample(3'd5, 1'b1, 16'h8000, -1, 0, 1'b0, 17'h10002);  // R5 top bit
        do_sample(3'd0, 1'b0, 16'h0100, 4, 1, 1'b0, 17'h00100);   // R3 borrow between clears
        do_sample(3'd4, 1'b1, 16'h0042, -1, 0, 1'b1, 17'h00086);  // R8 intruding start
        do_error(3'd6, 2'd1, "R6 inactive channel");
        do_error(3'd7, 2'd2, "R7 idle channel");
        do_sample(3'd1, 1'b0, 16'h0010, -1, 0, 1'b0, 17'h00011);

        for (int i = 0; i < 40; i++) begin
            logic [2:0] ch;
            ch = 3'($urandom % 6);
            do_sample(ch, 1'($urandom), 16'($urandom), int'($urandom % 7),
                      1 + int'($urandom % 3), 1'($urandom % 4 == 0), -1);
            if (i % 10 == 9) do_error(3'd6 + 3'(i % 2), 2'd1 + 2'(i % 2), "R6/R7 mixed");
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule